// File: doc/BRIEF.md
# Trigger Holdoff, Delay and Capture Control

This block sits after the trigger-combining logic of a two-channel sampling path. It receives one combined raw trigger and turns it into accepted trigger events. After each accepted event it holds off further events for a programmable number of clocks. It can also lock onto the first event for as long as streaming capture is selected.

Each accepted event produces a fast trigger for an attached instrument, with a fixed lag of two clocks. It also sets a sticky status flag. It starts a delay measured in valid samples, after which a single-cycle main trigger pulse appears. That pulse is aligned with the output sample at which capture should begin.

Both sample channels run through a fixed four-stage pipeline, so data and the main trigger stay in step. When embedding is selected, the main trigger is carried in the most significant bit of each output word. A consumer with an unknown pipeline length can then recover it from the data itself.

Top module: `trig_post_proc`

## Requirements
- R1: While `rst_ni` is low, every output is 0: both triggers, the status flag, both data words and both valid strobes.
- R2: An accepted event for a raw trigger that is high in cycle t drives `trig_fast_o` high in cycle t+2.
- R3: An accepted event loads a holdoff counter with `holdoff_i`, and the counter then decrements once per clock. While the counter is nonzero, a high raw trigger is ignored. With the raw trigger held high and holdoff H, accepted events therefore occur every H+1 clocks.
- R4: With `delay_i` = 0 and a valid sample in every clock, `trig_out_o` is high 4 clocks after the raw trigger cycle.
- R5: The sample strobe is `valid_a_i`. With delay D, `trig_out_o` is high in the cycle the outputs present the (D+1)-th valid sample taken at or after the raw trigger cycle. With a valid sample in every clock, this is 4+D clocks after the raw trigger cycle.
- R6: Each accepted event gives exactly one single-cycle pulse on `trig_out_o`, provided events are spaced wider than the delay.
- R7: `triggered_o` is set 2 clocks after the raw trigger cycle of an accepted event. It stays set until a cycle with `status_clr_i` high, and it reads 0 after that clock edge. If a set and a clear fall in the same cycle, the flag stays set.
- R8: While `stream_en_i` is high, the first accepted event blocks all later events: `trig_fast_o`, `trig_out_o` and `triggered_o` do not react to them. Events are accepted again once `stream_en_i` has been low for one clock.
- R9: With `embed_en_i` high, bit 15 of both output words equals `trig_out_o` in the same cycle, and bits 14:0 carry the sample. With `embed_en_i` low, all 16 bits pass unchanged.
- R10: Output data words and valid strobes lag their inputs by exactly 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_raw_i | input | 1 | Combined raw trigger |
| data_a_i | input | 16 | Channel A sample, two's complement |
| data_b_i | input | 16 | Channel B sample, two's complement |
| valid_a_i | input | 1 | Channel A sample valid; acts as the delay sample strobe |
| valid_b_i | input | 1 | Channel B sample valid |
| holdoff_i | input | 32 | Holdoff length in clocks |
| delay_i | input | 32 | Capture delay in valid samples |
| stream_en_i | input | 1 | Streaming capture select |
| embed_en_i | input | 1 | Embed the trigger in output bit 15 |
| status_clr_i | input | 1 | Clear pulse for the sticky status flag |
| trig_fast_o | output | 1 | Accepted event, fixed 2-clock lag |
| trig_out_o | output | 1 | Delayed main trigger pulse |
| triggered_o | output | 1 | Sticky triggered status |
| data_a_o | output | 16 | Channel A output word |
| data_b_o | output | 16 | Channel B output word |
| valid_a_o | output | 1 | Channel A output valid |
| valid_b_o | output | 1 | Channel B output valid |

## Verification
The hardest case to reach from the ports is a delay count that must skip invalid samples, including an invalid sample in the very cycle of the trigger. To get there, the bench drives `valid_a_i` from the parity of a running sample index. It places the raw trigger on an even (invalid) index, so the pulse must land on the third odd sample. The bench checks that cycle's output word against the index it drove. Holdoff spacing is reached by holding the raw trigger high for many clocks and counting the fast pulses. A coincident set and clear of the status flag is reached by asserting the clear in the cycle of acceptance.

// File: rtl/trig_pp_pkg.sv
`timescale 1ns/1ps
package trig_pp_pkg;
  localparam int unsigned CNT_W    = 32;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned PIPE_LAT = 4;
endpackage

// File: rtl/trig_holdoff_gate.sv
`timescale 1ns/1ps
module trig_holdoff_gate #(
  parameter int unsigned CNT_W = trig_pp_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_raw_i,
  input  logic [CNT_W-1:0] holdoff_i,
  input  logic             stream_en_i,
  input  logic             status_clr_i,
  output logic             acc_o,
  output logic             triggered_o
);
  logic             raw_q;
  logic [CNT_W-1:0] ho_cnt;
  logic             stream_lat;
  logic             accept;
  logic             acc_q;
  logic             status_q;

  assign accept = raw_q && (ho_cnt == '0) && !stream_lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q      <= 1'b0;
      ho_cnt     <= '0;
      stream_lat <= 1'b0;
      acc_q      <= 1'b0;
      status_q   <= 1'b0;
    end else begin
      raw_q <= trig_raw_i;
      acc_q <= accept;
      if (accept)             ho_cnt <= holdoff_i;
      else if (ho_cnt != '0)  ho_cnt <= ho_cnt - 1'b1;
      if (!stream_en_i)       stream_lat <= 1'b0;
      else if (accept)        stream_lat <= 1'b1;
      // set has priority over a coincident clear
      if (accept)             status_q <= 1'b1;
      else if (status_clr_i)  status_q <= 1'b0;
    end
  end

  assign acc_o       = acc_q;
  assign triggered_o = status_q;

  AST_HOLDOFF_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ho_cnt != '0) |=> !acc_q);  // R3
  AST_HOLDOFF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_q) |-> (ho_cnt == $past(holdoff_i)));  // R3
  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> status_q);  // R7
  AST_STREAM_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stream_lat && stream_en_i) |=> !acc_q);  // R8
endmodule

// File: rtl/trig_delay_unit.sv
`timescale 1ns/1ps
module trig_delay_unit #(
  parameter int unsigned CNT_W = trig_pp_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic             smp_vld_i,
  output logic             fire_o,
  output logic             trig_out_o
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             fire;
  logic             trig_q;

  assign fire = active && smp_vld_i && (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      cnt    <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= fire;
      if (acc_i) begin
        active <= 1'b1;
        cnt    <= delay_i;
      end else if (active && smp_vld_i) begin
        if (cnt == '0) active <= 1'b0;
        else           cnt    <= cnt - 1'b1;
      end
    end
  end

  assign fire_o     = fire;
  assign trig_out_o = trig_q;

  AST_OUT_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_out_o |-> $past(smp_vld_i));  // R5
  AST_ZERO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && (delay_i == '0)) ##1 smp_vld_i |=> trig_out_o);  // R4
endmodule

// File: rtl/trig_data_embed.sv
`timescale 1ns/1ps
module trig_data_embed #(
  parameter int unsigned DATA_W   = trig_pp_pkg::DATA_W,
  parameter int unsigned NUM_CH   = trig_pp_pkg::NUM_CH,
  parameter int unsigned PIPE_LAT = trig_pp_pkg::PIPE_LAT
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  data_i,
  input  logic [NUM_CH-1:0]              vld_i,
  input  logic                           fire_i,
  input  logic                           embed_en_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  data_o,
  output logic [NUM_CH-1:0]              vld_o,
  output logic                           smp_vld_o
);
  localparam int unsigned MID = PIPE_LAT - 1;

  logic [NUM_CH-1:0] tap;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] d_q [MID];
    logic [MID-1:0]    v_q;
    logic [DATA_W-1:0] out_q;
    logic              vout_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < int'(MID); s++) d_q[s] <= '0;
        v_q    <= '0;
        out_q  <= '0;
        vout_q <= 1'b0;
      end else begin
        d_q[0] <= data_i[c];
        v_q[0] <= vld_i[c];
        for (int s = 1; s < int'(MID); s++) begin
          d_q[s] <= d_q[s-1];
          v_q[s] <= v_q[s-1];
        end
        out_q  <= embed_en_i ? {fire_i, d_q[MID-1][DATA_W-2:0]} : d_q[MID-1];
        vout_q <= v_q[MID-1];
      end
    end

    assign tap[c]    = v_q[MID-1];
    assign data_o[c] = out_q;
    assign vld_o[c]  = vout_q;
  end

  assign smp_vld_o = tap[0];
endmodule

// File: rtl/trig_post_proc.sv
`timescale 1ns/1ps
module trig_post_proc #(
  parameter int unsigned CNT_W    = trig_pp_pkg::CNT_W,
  parameter int unsigned DATA_W   = trig_pp_pkg::DATA_W,
  parameter int unsigned PIPE_LAT = trig_pp_pkg::PIPE_LAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_raw_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic [DATA_W-1:0] data_b_i,
  input  logic              valid_a_i,
  input  logic              valid_b_i,
  input  logic [CNT_W-1:0]  holdoff_i,
  input  logic [CNT_W-1:0]  delay_i,
  input  logic              stream_en_i,
  input  logic              embed_en_i,
  input  logic              status_clr_i,
  output logic              trig_fast_o,
  output logic              trig_out_o,
  output logic              triggered_o,
  output logic [DATA_W-1:0] data_a_o,
  output logic [DATA_W-1:0] data_b_o,
  output logic              valid_a_o,
  output logic              valid_b_o
);
  localparam int unsigned NCH = 2;

  logic                          acc;
  logic                          fire;
  logic                          smp_vld;
  logic [NCH-1:0][DATA_W-1:0]    d_in;
  logic [NCH-1:0][DATA_W-1:0]    d_out;
  logic [NCH-1:0]                v_in;
  logic [NCH-1:0]                v_out;

  assign d_in = {data_b_i, data_a_i};
  assign v_in = {valid_b_i, valid_a_i};

  trig_holdoff_gate #(.CNT_W(CNT_W)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_raw_i   (trig_raw_i),
    .holdoff_i    (holdoff_i),
    .stream_en_i  (stream_en_i),
    .status_clr_i (status_clr_i),
    .acc_o        (acc),
    .triggered_o  (triggered_o)
  );

  trig_delay_unit #(.CNT_W(CNT_W)) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .delay_i    (delay_i),
    .smp_vld_i  (smp_vld),
    .fire_o     (fire),
    .trig_out_o (trig_out_o)
  );

  trig_data_embed #(.DATA_W(DATA_W), .NUM_CH(NCH), .PIPE_LAT(PIPE_LAT)) u_embed (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (d_in),
    .vld_i      (v_in),
    .fire_i     (fire),
    .embed_en_i (embed_en_i),
    .data_o     (d_out),
    .vld_o      (v_out),
    .smp_vld_o  (smp_vld)
  );

  assign trig_fast_o = acc;
  assign data_a_o    = d_out[0];
  assign data_b_o    = d_out[1];
  assign valid_a_o   = v_out[0];
  assign valid_b_o   = v_out[1];

  AST_EMBED_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(embed_en_i) |-> (data_a_o[DATA_W-1] == trig_out_o) && (data_b_o[DATA_W-1] == trig_out_o));  // R9
endmodule

// File: tb/trig_post_proc_tb_top.sv
`timescale 1ns/1ps
module trig_post_proc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_raw_i = 1'b0;
  logic [15:0] data_a_i = '0, data_b_i = '0;
  logic        valid_a_i = 1'b0, valid_b_i = 1'b0;
  logic [31:0] holdoff_i = '0, delay_i = '0;
  logic        stream_en_i = 1'b0, embed_en_i = 1'b0, status_clr_i = 1'b0;
  logic        trig_fast_o, trig_out_o, triggered_o, valid_a_o, valid_b_o;
  logic [15:0] data_a_o, data_b_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit vld_mode = 1'b0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  trig_post_proc dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_raw_i(trig_raw_i),
    .data_a_i(data_a_i), .data_b_i(data_b_i), .valid_a_i(valid_a_i), .valid_b_i(valid_b_i),
    .holdoff_i(holdoff_i), .delay_i(delay_i), .stream_en_i(stream_en_i),
    .embed_en_i(embed_en_i), .status_clr_i(status_clr_i),
    .trig_fast_o(trig_fast_o), .trig_out_o(trig_out_o), .triggered_o(triggered_o),
    .data_a_o(data_a_o), .data_b_o(data_b_o), .valid_a_o(valid_a_o), .valid_b_o(valid_b_o)
  );

  // [15] embed, [14:8] delay, [7:0] expected trig_out lag
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 7'd0, 8'd4}, {1'b1, 7'd1, 8'd5}, {1'b0, 7'd2, 8'd6},
    {1'b1, 7'd3, 8'd7}, {1'b1, 7'd5, 8'd9}, {1'b0, 7'd8, 8'd12}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    cyc++;
    data_a_i  = 16'h8000 | 16'(cyc & 32'h7fff);
    data_b_i  = 16'(cyc & 32'h7fff);
    valid_a_i = vld_mode ? cyc[0] : 1'b1;
    valid_b_i = valid_a_i;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, first, pulses;
    #7;
    chk("R1 fast in reset", trig_fast_o, 0);
    chk("R1 out in reset", trig_out_o, 0);
    chk("R1 status in reset", triggered_o, 0);
    chk("R1 data in reset", {data_a_o, data_b_o}, 0);
    chk("R1 valid in reset", {valid_a_o, valid_b_o}, 0);
    @(posedge clk_i); #1; rst_ni = 1'b1;
    drain(6);

    // table-driven delay / embed / latency cases
    for (int i = 0; i < 6; i++) begin
      int d, lat;
      bit emb;
      emb = VEC[i][15]; d = int'(VEC[i][14:8]); lat = int'(VEC[i][7:0]);
      delay_i = 32'(d); embed_en_i = emb; holdoff_i = 0;
      step();
      c0 = cyc; trig_raw_i = 1'b1;
      step(); trig_raw_i = 1'b0;
      first = 0; pulses = 0;
      for (int k = 1; k <= lat + 4; k++) begin
        if (k == 1) chk("R9 msb off-pulse", data_a_o[15], emb ? 0 : 1);
        if (k == 2) chk("R2 fast lag", trig_fast_o, 1);
        if (trig_out_o) begin
          pulses++;
          if (first == 0) begin
            first = k;
            chk("R10 data lag", data_b_o[14:0], (c0 + d) & 32'h7fff);
            chk("R10 valid lag", {valid_a_o, valid_b_o}, 2'b11);
            chk("R9 msb at pulse", data_b_o[15], emb);
          end
        end
        step();
      end
      chk("R4 R5 out lag", first, lat);
      chk("R6 single pulse", pulses, 1);
      drain(6);
    end
    embed_en_i = 1'b0; delay_i = 0;

    // R3 holdoff with raw held high
    holdoff_i = 3;
    trig_raw_i = 1'b1;
    step();
    pulses = 0;
    for (int k = 1; k <= 20; k++) begin
      if (trig_fast_o) pulses++;
      if (k == 3) chk("R3 ignored in holdoff", trig_fast_o, 0);
      if (k == 6) chk("R3 reaccept after holdoff", trig_fast_o, 1);
      step();
    end
    chk("R3 holdoff spacing", pulses, 5);
    holdoff_i = 0;
    pulses = 0;
    for (int k = 1; k <= 5; k++) begin
      step();
      if (trig_fast_o) pulses++;
    end
    chk("R3 zero holdoff every clock", pulses, 5);
    trig_raw_i = 1'b0;
    drain(8);

    // R7 sticky status
    status_clr_i = 1'b1; step(); status_clr_i = 1'b0;
    chk("R7 cleared", triggered_o, 0);
    trig_raw_i = 1'b1; step(); trig_raw_i = 1'b0;
    status_clr_i = 1'b1; step(); status_clr_i = 1'b0;
    chk("R7 set wins over clear", triggered_o, 1);
    drain(5);
    chk("R7 sticky hold", triggered_o, 1);
    status_clr_i = 1'b1; step(); status_clr_i = 1'b0;
    chk("R7 w1c", triggered_o, 0);
    drain(4);

    // R8 streaming
    stream_en_i = 1'b1;
    step();
    trig_raw_i = 1'b1; step(); trig_raw_i = 1'b0;
    pulses = 0; first = 0;
    for (int k = 1; k <= 8; k++) begin
      if (trig_fast_o) pulses++;
      if (trig_out_o) first++;
      step();
    end
    chk("R8 first event fast", pulses, 1);
    chk("R8 first event out", first, 1);
    status_clr_i = 1'b1; step(); status_clr_i = 1'b0;
    trig_raw_i = 1'b1; step(); trig_raw_i = 1'b0;
    pulses = 0; first = 0;
    for (int k = 1; k <= 8; k++) begin
      if (trig_fast_o) pulses++;
      if (trig_out_o) first++;
      step();
    end
    chk("R8 later fast ignored", pulses, 0);
    chk("R8 later out ignored", first, 0);
    chk("R8 status untouched", triggered_o, 0);
    stream_en_i = 1'b0;
    step();
    trig_raw_i = 1'b1; step(); trig_raw_i = 1'b0;
    pulses = 0;
    for (int k = 1; k <= 6; k++) begin
      if (trig_fast_o) pulses++;
      step();
    end
    chk("R8 rearmed", pulses, 1);
    drain(6);

    // R5 delay counts only valid samples, trigger on invalid sample
    vld_mode = 1'b1; delay_i = 2;
    step();
    while (cyc[0]) step();
    c0 = cyc; trig_raw_i = 1'b1;
    step(); trig_raw_i = 1'b0;
    first = 0; pulses = 0;
    for (int k = 1; k <= 14; k++) begin
      if (trig_out_o) begin
        pulses++;
        if (first == 0) begin
          first = k;
          chk("R5 sample at pulse", data_a_o[14:0], (c0 + 5) & 32'h7fff);
          chk("R5 sample valid at pulse", valid_a_o, 1);
        end
      end
      step();
    end
    chk("R5 gapped delay lag", first, 9);
    chk("R6 gapped single pulse", pulses, 1);
    vld_mode = 1'b0;
    drain(4);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule